// File: doc/BRIEF.md
# Predicated Truncating Vector Byte-Store Sequencer

This block turns one vector store operation into a series of single-byte memory writes. It takes the following operands:

- a vector register value;
- a per-byte governing predicate;
- a 2-bit element-size code;
- two candidate 64-bit base addresses: a general one and a stack one;
- a 64-bit starting index;
- the 5-bit selectors that named the base and index registers.

After a start pulse it walks the elements from lowest to highest. For each element whose governing predicate bit is set, it offers one write on a valid/ready port. The write carries the element's least significant byte and goes to base plus index plus element number.

Inactive elements produce no write, but they still use up their address slot. The running index stays inside the block and is never returned. When the walk ends, a one-cycle done pulse is raised, even if nothing was written. An index selector of 31 is an illegal encoding: the block raises a one-cycle error pulse instead of running.

Top module: `byte_scatter_store`

## Requirements
- R1: The size code `sz` selects the element width as 8<<sz bits (0:8, 1:16, 2:32, 3:64). The walk covers VLEN/(8<<sz) elements, numbered from 0.
- R2: The write for element e goes to address base + index + e, computed modulo 2^64.
- R3: The write data is bits [7:0] of element e, which is vector bits [e*(8<<sz)+7 : e*(8<<sz)]. All higher bits of the element are dropped.
- R4: An element whose governing bit is 0 produces no write, yet the following elements keep their address e.
- R5: The governing bit of element e is predicate bit e<<sz, that is, one predicate bit per vector byte.
- R6: A start with index selector equal to 31 gives `err` high for exactly one cycle, no write and no `done`.
- R7: A base selector of 31 takes `sp_base` as the base. Any other value takes `gp_base`.
- R8: Writes appear in ascending element order, at most one per accepted handshake. While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_byte` hold their values.
- R9: `done` is high for exactly one cycle after the last element is handled. This includes an operation in which no element is active.
- R10: A start asserted while `busy` is high is ignored and does not alter the running operation.
- R11: After reset, `wr_valid`, `done`, `err` and `busy` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only while idle) |
| size_code | input | 2 | Element-size code |
| vec_data | input | VLEN | Source vector |
| pred | input | VLEN/8 | Governing predicate, one bit per byte |
| base_sel | input | 5 | Base register selector (31 selects the stack base) |
| idx_sel | input | 5 | Index register selector (31 is illegal) |
| gp_base | input | 64 | General base address |
| sp_base | input | 64 | Stack base address |
| idx_val | input | 64 | Starting element index |
| wr_valid | output | 1 | Byte write offered |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | 64 | Byte write address |
| wr_byte | output | 8 | Byte write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle illegal-encoding pulse |

## Verification
The hardest situations to reach from the ports are a write stalled under backpressure and a second start that arrives while that write is held. The stimulus forces them with a ready pattern that withholds acceptance for several cycles, and with a start pulse raised in the middle of a stalled walk but carrying different operands. Every write that is seen is then compared in order against an expected list built from the predicate, the size code and the base. Address wrap past 2^64 is reached by placing the base at the top of the address space with a nonzero index.

// File: rtl/bss_pkg.sv
package bss_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_PUSH = 2'd2
  } bss_state_t;

  localparam logic [4:0] SEL_SPECIAL = 5'd31;
endpackage

// File: rtl/bss_elem_sel.sv
module bss_elem_sel #(
  parameter int VLEN = 128,
  localparam int NB  = VLEN / 8,
  localparam int EW  = $clog2(NB)
) (
  input  logic [VLEN-1:0] vec,
  input  logic [NB-1:0]   pred,
  input  logic [1:0]      size,
  input  logic [EW-1:0]   elem,
  output logic [7:0]      lane_byte,
  output logic            active,
  output logic            last
);
  logic [7:0]    bytes [NB];
  logic [EW-1:0] byte_off;
  logic [EW:0]   n_elem;

  for (genvar g = 0; g < NB; g++) begin : g_bytes
    assign bytes[g] = vec[g*8 +: 8];
  end

  always_comb begin
    byte_off  = elem << size;
    lane_byte = bytes[byte_off];
    active    = pred[byte_off];
    n_elem    = (EW+1)'(NB) >> size;
    last      = ({1'b0, elem} == n_elem - 1'b1);
  end
endmodule

// File: rtl/bss_wport.sv
module bss_wport (
  input  logic        clk,
  input  logic        rst,
  input  logic        issue,
  input  logic [63:0] addr_in,
  input  logic [7:0]  byte_in,
  input  logic        wr_ready,
  output logic        wr_valid,
  output logic [63:0] wr_addr,
  output logic [7:0]  wr_byte
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_byte  <= '0;
    end else if (issue) begin
      wr_valid <= 1'b1;
      wr_addr  <= addr_in;
      wr_byte  <= byte_in;
    end else if (wr_valid && wr_ready) begin
      wr_valid <= 1'b0;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_byte))); // R8
  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
    issue |-> !wr_valid); // R8
endmodule

// File: rtl/bss_seq.sv
module bss_seq
  import bss_pkg::*;
#(
  parameter int EW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          idx_bad,
  input  logic          active,
  input  logic          last,
  input  logic          wr_fire,
  output logic          load,
  output logic          step,
  output logic          issue,
  output logic [EW-1:0] elem,
  output logic          busy,
  output logic          done,
  output logic          err
);
  bss_state_t state, state_n;
  logic       done_n, err_n;

  always_comb begin
    state_n = state;
    load    = 1'b0;
    step    = 1'b0;
    issue   = 1'b0;
    done_n  = 1'b0;
    err_n   = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        if (idx_bad) err_n = 1'b1;
        else begin
          load    = 1'b1;
          state_n = ST_SCAN;
        end
      end
      ST_SCAN: if (active) begin
        issue   = 1'b1;
        state_n = ST_PUSH;
      end else if (last) begin
        done_n  = 1'b1;
        state_n = ST_IDLE;
      end else begin
        step = 1'b1;
      end
      ST_PUSH: if (wr_fire) begin
        if (last) begin
          done_n  = 1'b1;
          state_n = ST_IDLE;
        end else begin
          step    = 1'b1;
          state_n = ST_SCAN;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      elem  <= '0;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      state <= state_n;
      done  <= done_n;
      err   <= err_n;
      if (load)      elem <= '0;
      else if (step) elem <= elem + 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
    err |=> !err); // R6
  AST_ERR_STAYS_IDLE: assert property (@(posedge clk) disable iff (rst)
    err |-> (!busy && !done)); // R6
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !step) |=> $stable(elem)); // R10
endmodule

// File: rtl/byte_scatter_store.sv
module byte_scatter_store
  import bss_pkg::*;
#(
  parameter int VLEN = 128,
  localparam int NB  = VLEN / 8,
  localparam int EW  = $clog2(NB)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [1:0]      size_code,
  input  logic [VLEN-1:0] vec_data,
  input  logic [NB-1:0]   pred,
  input  logic [4:0]      base_sel,
  input  logic [4:0]      idx_sel,
  input  logic [63:0]     gp_base,
  input  logic [63:0]     sp_base,
  input  logic [63:0]     idx_val,
  output logic            wr_valid,
  input  logic            wr_ready,
  output logic [63:0]     wr_addr,
  output logic [7:0]      wr_byte,
  output logic            busy,
  output logic            done,
  output logic            err
);
  logic [VLEN-1:0] vec_q;
  logic [NB-1:0]   pred_q;
  logic [1:0]      size_q;
  logic [63:0]     addr_q;
  logic            load, step, issue, active, last;
  logic [EW-1:0]   elem;
  logic [7:0]      lane_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q  <= '0;
      pred_q <= '0;
      size_q <= '0;
      addr_q <= '0;
    end else if (load) begin
      vec_q  <= vec_data;
      pred_q <= pred;
      size_q <= size_code;
      addr_q <= ((base_sel == SEL_SPECIAL) ? sp_base : gp_base) + idx_val;
    end else if (step) begin
      addr_q <= addr_q + 64'd1;
    end
  end

  bss_elem_sel #(.VLEN(VLEN)) u_sel (
    .vec(vec_q), .pred(pred_q), .size(size_q), .elem(elem),
    .lane_byte(lane_byte), .active(active), .last(last)
  );

  bss_seq #(.EW(EW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .idx_bad(idx_sel == SEL_SPECIAL),
    .active(active), .last(last), .wr_fire(wr_valid && wr_ready),
    .load(load), .step(step), .issue(issue), .elem(elem),
    .busy(busy), .done(done), .err(err)
  );

  bss_wport u_port (
    .clk(clk), .rst(rst), .issue(issue), .addr_in(addr_q), .byte_in(lane_byte),
    .wr_ready(wr_ready), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_byte(wr_byte)
  );

  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    err |-> !wr_valid); // R6
  AST_FIRE_RETIRES: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready) |=> !wr_valid); // R8
  AST_VALID_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> busy); // R9
endmodule

// File: tb/tb_byte_scatter_store.sv
module tb_byte_scatter_store;
  localparam int VLEN = 128;
  localparam int NB   = VLEN / 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic [1:0]      size_code = '0;
  logic [VLEN-1:0] vec_data = '0;
  logic [NB-1:0]   pred = '0;
  logic [4:0]      base_sel = '0, idx_sel = '0;
  logic [63:0]     gp_base = '0, sp_base = '0, idx_val = '0;
  logic            wr_ready = 1'b1;
  logic            wr_valid, busy, done, err;
  logic [63:0]     wr_addr;
  logic [7:0]      wr_byte;

  int tests = 0, fails = 0;
  int bp_mode = 0;
  int cyc = 0;

  logic [63:0] got_addr [64];
  logic [7:0]  got_byte [64];
  int          n_got = 0;
  logic [63:0] exp_addr [64];
  logic [7:0]  exp_byte [64];
  int          n_exp = 0;
  logic        held = 1'b0;
  logic [63:0] held_addr;
  logic [7:0]  held_byte;
  int          hold_bad = 0;

  always #10 clk = ~clk;

  byte_scatter_store #(.VLEN(VLEN)) dut (
    .clk(clk), .rst(rst), .start(start), .size_code(size_code),
    .vec_data(vec_data), .pred(pred), .base_sel(base_sel), .idx_sel(idx_sel),
    .gp_base(gp_base), .sp_base(sp_base), .idx_val(idx_val),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_byte(wr_byte),
    .busy(busy), .done(done), .err(err)
  );

  // memory model: set ready, then log the handshake taken at the next edge
  always @(negedge clk) begin
    cyc++;
    if (held && !(wr_valid && wr_addr == held_addr && wr_byte == held_byte)) hold_bad++;
    if (bp_mode == 0) wr_ready = 1'b1;
    else              wr_ready = ((cyc % 4) == 3);
    held = wr_valid && !wr_ready;
    held_addr = wr_addr;
    held_byte = wr_byte;
    if (wr_valid && wr_ready && n_got < 64) begin
      got_addr[n_got] = wr_addr;
      got_byte[n_got] = wr_byte;
      n_got++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic build_exp(input logic [63:0] base, input logic [63:0] idx);
    int ne = NB >> size_code;
    n_exp = 0;
    for (int e = 0; e < ne; e++) begin
      int bo = e << size_code;
      if (pred[bo]) begin
        exp_addr[n_exp] = base + idx + 64'(e);
        exp_byte[n_exp] = vec_data[bo*8 +: 8];
        n_exp++;
      end
    end
  endtask

  task automatic run_op(input string req, input logic [1:0] sz, input logic [VLEN-1:0] v,
                        input logic [NB-1:0] p, input logic [4:0] bsel,
                        input logic [63:0] gpb, input logic [63:0] spb, input logic [63:0] idx,
                        input int bp, input bit restart);
    int waitc = 0;
    @(negedge clk);
    size_code = sz; vec_data = v; pred = p; base_sel = bsel; idx_sel = 5'd2;
    gp_base = gpb; sp_base = spb; idx_val = idx; bp_mode = bp;
    build_exp((bsel == 5'd31) ? spb : gpb, idx);
    n_got = 0; hold_bad = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (restart) begin
      repeat (3) @(negedge clk);
      gp_base = 64'hDEAD_0000; sp_base = 64'hBEEF_0000; pred = '1; idx_val = 64'h40;
      start = 1'b1;   // R10: must be ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && waitc < 2000) begin
      @(negedge clk);
      waitc++;
    end
    check(done === 1'b1, {req, " done seen"}, 64'(done), 64'd1);
    @(negedge clk);
    check(done === 1'b0, "R9 done one cycle", 64'(done), 64'd0);
    check(n_got == n_exp, {req, " write count"}, 64'(n_got), 64'(n_exp));
    for (int i = 0; i < n_exp && i < n_got; i++) begin
      check(got_addr[i] == exp_addr[i], {req, " addr"}, got_addr[i], exp_addr[i]);
      check(got_byte[i] == exp_byte[i], {req, " byte"}, 64'(got_byte[i]), 64'(exp_byte[i]));
    end
    check(hold_bad == 0, "R8 hold under stall", 64'(hold_bad), 64'd0);
    bp_mode = 0;
  endtask

  task automatic t_reset();
    check(wr_valid === 1'b0, "R11 wr_valid", 64'(wr_valid), 0);
    check(done === 1'b0, "R11 done", 64'(done), 0);
    check(err === 1'b0, "R11 err", 64'(err), 0);
    check(busy === 1'b0, "R11 busy", 64'(busy), 0);
  endtask

  task automatic t_illegal();
    int errs = 0, dones = 0;
    @(negedge clk);
    pred = '1; idx_sel = 5'd31; n_got = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 10; i++) begin
      if (err) errs++;
      if (done) dones++;
      @(negedge clk);
    end
    check(errs == 1, "R6 err one cycle", 64'(errs), 1);
    check(dones == 0, "R6 no done", 64'(dones), 0);
    check(n_got == 0, "R6 no writes", 64'(n_got), 0);
    idx_sel = 5'd2;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [VLEN-1:0] pat;
    for (int i = 0; i < NB; i++) pat[i*8 +: 8] = 8'(8'h11 * (i + 1) ^ 8'hA0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    // R1 R2 R3: byte elements, all active
    run_op("R1 R3 byte", 2'd0, pat, '1, 5'd3, 64'h1000, 64'h0, 64'h5, 0, 1'b0);
    // R4 R5 R8: halfword, sparse predicate, backpressure
    run_op("R5 R4 half", 2'd1, pat, 16'b0100_0001_0000_0100, 5'd3, 64'h2000, 64'h0, 64'h10, 1, 1'b0);
    // R7: word, stack base
    run_op("R7 word sp", 2'd2, pat, 16'h1111, 5'd31, 64'h3000, 64'h7700, 64'h1, 0, 1'b0);
    // R2: doubleword, wrap past 2^64
    run_op("R2 dword wrap", 2'd3, pat, 16'h0101, 5'd4, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h1, 1, 1'b0);
    // R9 R4: no element active
    run_op("R9 none active", 2'd0, pat, '0, 5'd1, 64'h4000, 64'h0, 64'h0, 0, 1'b0);
    // R10: start during busy ignored
    run_op("R10 restart", 2'd0, pat, 16'hF00F, 5'd1, 64'h5000, 64'h0, 64'h3, 1, 1'b1);
    t_illegal();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule